// File: doc/BRIEF.md
# Handshaked Byte Input Port

This block receives bytes from a slow peripheral one at a time and hands them to a processor that polls for them. The peripheral raises a valid line with a byte on its data pins. The port registers the byte, raises an acknowledge line back to the peripheral, and sets a ready flag that the processor can read. The acknowledge stays high until the processor has cleared the flag. This back-pressure keeps the peripheral from overrunning a byte that has not been consumed.

The processor side has a chip select, a one-bit register select, a read strobe and a write strobe. Register select 0 returns the captured byte. Register select 1 returns the status word, whose bit 0 is the ready flag. A build-time parameter picks how the flag is cleared: either a read of the data register clears it, or the processor writes a 1 to the flag bit. The valid line is asynchronous to the port clock, so it passes through a synchronizer first. Only its rising edge starts a capture.

Top module: `hs_byte_in_port`

## Requirements
- R1: A synchronous active-high `rst` clears the ready flag, the data register and `dev_ack` to 0.
- R2: A capture happens when `dev_valid` is sampled high at a clock edge while `dev_ack` is low. On the third rising clock edge, counting that sampling edge as the first, the port loads `dev_data` into the data register and sets both the ready flag and `dev_ack` to 1.
- R3: A `dev_valid` that stays high causes exactly one capture. A new capture needs `dev_valid` to go low and then high again.
- R4: While the ready flag is 1, `dev_ack` stays 1, whatever `dev_valid` does.
- R5: A rising edge of `dev_valid` that arrives while `dev_ack` is high is ignored, and the data register keeps its value.
- R6: `dev_ack` falls on the clock edge that follows the edge at which the ready flag was cleared.
- R7: With `cs`=1 and `rd_en`=1, `rsel`=0 returns the data register and `rsel`=1 returns the status word, which holds the flag in bit 0 and zeros in every other bit. With `cs`=0 or `rd_en`=0, `rdata` is 0 and no clear happens.
- R8: With `CLEAR_ON_READ`=1, a read of `rsel`=0 clears the flag at that clock edge. A status read does not clear it, and writes have no effect.
- R9: With `CLEAR_ON_READ`=0, a write to `rsel`=1 with `wr_bit`=1 clears the flag. A write with `wr_bit`=0 and a data read leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Processor chip select |
| rsel | input | 1 | Register select: 0 data, 1 status |
| rd_en | input | 1 | Processor read strobe |
| wr_en | input | 1 | Processor write strobe |
| wr_bit | input | 1 | Written value of the status flag bit |
| rdata | output | DATA_W | Read data; 0 when no read is active |
| dev_data | input | DATA_W | Byte from the peripheral |
| dev_valid | input | 1 | Peripheral data-valid, asynchronous |
| dev_ack | output | 1 | Data-accepted to the peripheral |

## Verification
The bound checker watches, on every cycle, the fixed relations between the internal events: the flag implies acknowledge, a capture loads the presented byte, the data register is frozen while acknowledge is high, acknowledge is released one cycle after the flag drops, and the flag changes only at a capture or a clear. The bench's scenarios show the properties that depend on a sequence of events: the three-edge capture latency, a single capture for a held-high valid, the loss of a valid pulse that arrives during back-pressure, and the different clear rules of the two build variants. It builds both variants side by side and drives them with the same stimulus.

// File: rtl/hsp_pkg.sv
package hsp_pkg;

  typedef enum logic {
    SEL_DATA = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;

  // rising-edge detect between a current and a delayed level
  function automatic logic edge_up(input logic now_lvl, input logic was_lvl);
    return now_lvl & ~was_lvl;
  endfunction

endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  import hsp_pkg::*;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = edge_up(chain_q[STAGES-1], prev_q);

endmodule

// File: rtl/hsp_capture.sv
module hsp_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic [DATA_W-1:0] dev_data_i,
  input  logic              clr_i,
  output logic              take_o,
  output logic [DATA_W-1:0] data_q,
  output logic              flag_q,
  output logic              ack_q
);

  // a capture is allowed only when the previous handshake has ended
  assign take_o = rise_i & ~ack_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      flag_q <= 1'b0;
      ack_q  <= 1'b0;
    end else if (take_o) begin
      data_q <= dev_data_i;
      flag_q <= 1'b1;
      ack_q  <= 1'b1;
    end else begin
      if (clr_i)            flag_q <= 1'b0;
      if (ack_q && !flag_q) ack_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/hsp_regif.sv
module hsp_regif #(
  parameter int DATA_W        = 8,
  parameter bit CLEAR_ON_READ = 1'b1
) (
  input  logic              cs,
  input  logic              rsel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              wr_bit,
  input  logic [DATA_W-1:0] data_q,
  input  logic              flag_q,
  output logic [DATA_W-1:0] rdata,
  output logic              clr_o
);
  import hsp_pkg::*;

  function automatic logic [DATA_W-1:0] status_word(input logic f);
    logic [DATA_W-1:0] w;
    w    = '0;
    w[0] = f;
    return w;
  endfunction

  logic rd_act, rd_clr, wr_clr;

  assign rd_act = cs & rd_en;
  assign rd_clr = rd_act & (reg_sel_e'(rsel) == SEL_DATA) & flag_q;
  assign wr_clr = cs & wr_en & (reg_sel_e'(rsel) == SEL_STAT) & wr_bit & flag_q;
  assign clr_o  = CLEAR_ON_READ ? rd_clr : wr_clr;

  always_comb begin
    if (!rd_act)                               rdata = '0;
    else if (reg_sel_e'(rsel) == SEL_STAT)     rdata = status_word(flag_q);
    else                                       rdata = data_q;
  end

endmodule

// File: rtl/hs_byte_in_port.sv
module hs_byte_in_port #(
  parameter int DATA_W        = 8,
  parameter int SYNC_STAGES   = 2,
  parameter bit CLEAR_ON_READ = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rsel,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              wr_bit,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] dev_data,
  input  logic              dev_valid,
  output logic              dev_ack
);

  // named internal events, observed by the bound checker
  logic              valid_lvl;
  logic              valid_rise;
  logic              take_evt;
  logic              clr_evt;
  logic [DATA_W-1:0] data_q;
  logic              flag_q;

  hsp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (dev_valid),
    .level_o (valid_lvl),
    .rise_o  (valid_rise)
  );

  hsp_capture #(.DATA_W(DATA_W)) u_cap (
    .clk        (clk),
    .rst        (rst),
    .rise_i     (valid_rise),
    .dev_data_i (dev_data),
    .clr_i      (clr_evt),
    .take_o     (take_evt),
    .data_q     (data_q),
    .flag_q     (flag_q),
    .ack_q      (dev_ack)
  );

  hsp_regif #(.DATA_W(DATA_W), .CLEAR_ON_READ(CLEAR_ON_READ)) u_regif (
    .cs     (cs),
    .rsel   (rsel),
    .rd_en  (rd_en),
    .wr_en  (wr_en),
    .wr_bit (wr_bit),
    .data_q (data_q),
    .flag_q (flag_q),
    .rdata  (rdata),
    .clr_o  (clr_evt)
  );

endmodule

// File: rtl/hsp_checker.sv
module hsp_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] dev_data,
  input logic              valid_lvl,
  input logic              valid_rise,
  input logic              take_evt,
  input logic              clr_evt,
  input logic [DATA_W-1:0] data_q,
  input logic              flag_q,
  input logic              dev_ack
);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!flag_q && !dev_ack && data_q == '0));

  // R2
  a_r2_capture_loads: assert property (@(posedge clk) disable iff (rst)
    take_evt |=> (flag_q && dev_ack && data_q == $past(dev_data)));

  // R3
  a_r3_rise_needs_low: assert property (@(posedge clk) disable iff (rst)
    valid_rise |=> !valid_rise);

  // R4
  a_r4_flag_holds_ack: assert property (@(posedge clk) disable iff (rst)
    flag_q |-> dev_ack);

  // R5
  a_r5_data_frozen: assert property (@(posedge clk) disable iff (rst)
    dev_ack |=> $stable(data_q));

  // R6
  a_r6_ack_release: assert property (@(posedge clk) disable iff (rst)
    (dev_ack && !flag_q) |=> !dev_ack);

  // R8, R9
  a_r8_clear_drops_flag: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> !flag_q);

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !clr_evt) |=> flag_q);

  // R2: a capture is only ever started from a high synchronized level
  a_r2_take_from_level: assert property (@(posedge clk) disable iff (rst)
    take_evt |-> (valid_lvl && valid_rise));

endmodule

bind hs_byte_in_port hsp_checker #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dev_data   (dev_data),
  .valid_lvl  (valid_lvl),
  .valid_rise (valid_rise),
  .take_evt   (take_evt),
  .clr_evt    (clr_evt),
  .data_q     (data_q),
  .flag_q     (flag_q),
  .dev_ack    (dev_ack)
);

// File: tb/hs_byte_in_port_bench.sv
module hs_byte_in_port_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0, rsel = 1'b0, rd_en = 1'b0, wr_en = 1'b0, wr_bit = 1'b0;
  logic [7:0] dev_data = 8'h00;
  logic       dev_valid = 1'b0;
  logic [7:0] rdata_a, rdata_b;
  logic       ack_a, ack_b;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  // variant A: read of data clears; variant B: write of 1 clears
  hs_byte_in_port u_hs_byte_in_port (
    .clk(clk), .rst(rst), .cs(cs), .rsel(rsel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_bit(wr_bit), .rdata(rdata_a), .dev_data(dev_data),
    .dev_valid(dev_valid), .dev_ack(ack_a)
  );

  hs_byte_in_port #(.CLEAR_ON_READ(1'b0)) u_hs_byte_in_port_wc (
    .clk(clk), .rst(rst), .cs(cs), .rsel(rsel), .rd_en(rd_en), .wr_en(wr_en),
    .wr_bit(wr_bit), .rdata(rdata_b), .dev_data(dev_data),
    .dev_valid(dev_valid), .dev_ack(ack_b)
  );

  // byte in [11:4], extra cycles valid stays high in [3:0]
  localparam logic [11:0] VEC [5] = '{
    {8'hA5, 4'd0}, {8'h5A, 4'd1}, {8'h00, 4'd3}, {8'hFF, 4'd2}, {8'h81, 4'd5}
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cpu_rd(input logic sel, output logic [7:0] ra, output logic [7:0] rb);
    cs = 1'b1; rd_en = 1'b1; rsel = sel;
    #1;
    ra = rdata_a; rb = rdata_b;
    @(negedge clk);
    cs = 1'b0; rd_en = 1'b0;
  endtask

  task automatic cpu_wr(input logic val);
    cs = 1'b1; wr_en = 1'b1; rsel = 1'b1; wr_bit = val;
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b0; wr_bit = 1'b0;
  endtask

  // drives valid high and checks the R2 latency; leaves valid high
  task automatic send(input logic [7:0] b, input string req);
    dev_data = b; dev_valid = 1'b1;
    repeat (2) @(negedge clk);
    chk(req, "ack before third edge", {7'd0, ack_a}, 8'd0);
    @(negedge clk);
    chk(req, "ack A at third edge", {7'd0, ack_a}, 8'd1);
    chk(req, "ack B at third edge", {7'd0, ack_b}, 8'd1);
  endtask

  task automatic clear_both();
    logic [7:0] ra, rb;
    cpu_rd(1'b0, ra, rb);
    cpu_wr(1'b1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] ra, rb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1", "ack A", {7'd0, ack_a}, 8'd0);
    cpu_rd(1'b1, ra, rb);
    chk("R1", "status A", ra, 8'h00);
    cpu_rd(1'b0, ra, rb);
    chk("R1", "data B", rb, 8'h00);

    // table walk: R2, R6, R7, R8, R9
    for (int i = 0; i < 5; i++) begin
      logic [7:0] b;
      b = VEC[i][11:4];
      send(b, "R2");
      repeat (VEC[i][3:0]) @(negedge clk);
      dev_valid = 1'b0;
      cpu_rd(1'b1, ra, rb);
      chk("R7", "status A flag", ra, 8'h01);
      chk("R8", "status read keeps flag B", rb, 8'h01);
      cpu_rd(1'b0, ra, rb);
      chk("R2", "data A", ra, b);
      chk("R2", "data B", rb, b);
      chk("R6", "ack A one cycle after clear", {7'd0, ack_a}, 8'd1);
      cpu_rd(1'b1, ra, rb);
      chk("R8", "data read clears A", ra, 8'h00);
      chk("R9", "data read keeps B", rb, 8'h01);
      chk("R6", "ack A released", {7'd0, ack_a}, 8'd0);
      chk("R9", "ack B held", {7'd0, ack_b}, 8'd1);
      cpu_wr(1'b0);
      cpu_rd(1'b1, ra, rb);
      chk("R9", "write 0 keeps B", rb, 8'h01);
      cpu_wr(1'b1);
      chk("R6", "ack B one cycle after clear", {7'd0, ack_b}, 8'd1);
      cpu_rd(1'b1, ra, rb);
      chk("R9", "write 1 clears B", rb, 8'h00);
      chk("R6", "ack B released", {7'd0, ack_b}, 8'd0);
    end

    // R5: new valid edge during back-pressure is ignored
    send(8'h3C, "R5");
    dev_valid = 1'b0;
    repeat (3) @(negedge clk);
    dev_data = 8'hC3; dev_valid = 1'b1;
    repeat (5) @(negedge clk);
    dev_valid = 1'b0;
    chk("R4", "ack held with flag", {7'd0, ack_a}, 8'd1);
    cpu_rd(1'b0, ra, rb);
    chk("R5", "data A kept", ra, 8'h3C);
    chk("R5", "data B kept", rb, 8'h3C);
    cpu_wr(1'b1);
    repeat (5) @(negedge clk);
    chk("R5", "no late capture A", {7'd0, ack_a}, 8'd0);
    chk("R5", "no late capture B", {7'd0, ack_b}, 8'd0);

    // R3 and R7: held-high valid, disabled reads
    send(8'h96, "R3");
    cs = 1'b0; rd_en = 1'b1; rsel = 1'b0;
    #1;
    chk("R7", "rdata zero without cs", rdata_a, 8'h00);
    @(negedge clk);
    rd_en = 1'b0;
    cpu_rd(1'b1, ra, rb);
    chk("R7", "no clear without cs", ra, 8'h01);
    clear_both();
    repeat (6) @(negedge clk);
    chk("R3", "held valid no recapture A", {7'd0, ack_a}, 8'd0);
    chk("R3", "held valid no recapture B", {7'd0, ack_b}, 8'd0);
    cpu_rd(1'b1, ra, rb);
    chk("R3", "status stays clear", ra | rb, 8'h00);
    dev_valid = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset in the middle of a handshake
    send(8'h7E, "R1");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    dev_valid = 1'b0;
    chk("R1", "ack after reset", {7'd0, ack_a | ack_b}, 8'd0);
    cpu_rd(1'b0, ra, rb);
    chk("R1", "data after reset", ra | rb, 8'h00);
    cpu_rd(1'b1, ra, rb);
    chk("R1", "flag after reset", ra | rb, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule